// File: doc/BRIEF.md
# Logic Analyzer Command Receiver

This block takes the byte stream delivered by a UART receiver and turns host commands for a sampling logic analyzer into control actions. A command is either a single opcode byte (short) or an opcode byte followed by four argument bytes (long). The most significant bit of the opcode byte selects between the two. Short commands raise a soft reset pulse, a run (arm) pulse, or start a four-byte identification reply. The reply goes out through a valid/ready transmit byte interface. Long commands end in a single write strobe. The strobe carries the opcode as an address, the assembled 32-bit argument, and a decoded register kind and trigger stage.

The host can recover from any byte position by sending zero bytes. After at most five consecutive zeros the parser is waiting for an opcode again, and at least one reset pulse has been issued. Every output pulse appears in the clock cycle after the byte that caused it was accepted.

Top module: `la_cmd_rx`

## Requirements
- R1: While rst_ni is low and after reset, reset_o, run_o, wr_o and tx_valid_o are low, and the parser waits for an opcode.
- R2: An accepted opcode byte 0x00 gives a one-cycle reset_o pulse in the next cycle. An accepted opcode byte 0x01 gives a one-cycle run_o pulse in the next cycle.
- R3: An accepted opcode byte 0x02 starts a reply of the bytes 0x31, 0x53, 0x4C, 0x4F in that order. tx_valid_o rises two cycles after the byte is accepted. Each byte is held stable until tx_ready_i is high at a clock edge.
- R4: Opcode bytes 0x03 to 0x7F produce no output, and the next byte is again taken as an opcode.
- R5: An opcode byte with bit 7 set is followed by four argument bytes, the first forming bits 7:0 and the last bits 31:24. In the cycle after the fourth argument byte is accepted, wr_o pulses for one cycle with wr_addr_o equal to the opcode and wr_data_o equal to the assembled word.
- R6: Argument bytes of any value, including 0x00, 0x01 and 0x02, are data only and have no short-command effect.
- R7: wr_kind_o encodes the target register: 1 for opcode 0x80 (divider), 2 for 0x81 (capture size), 3 for 0x82 (flags), 0 for any long opcode not listed in R7 or R8.
- R8: Opcode 0xC0 + 4*s + k with stage s below NUM_STAGES gives wr_stage_o = s and wr_kind_o = 4 for k = 0 (trigger mask), 5 for k = 1 (trigger value), 6 for k = 2 (trigger config). k = 3 gives kind 0.
- R9: After five consecutive accepted zero bytes, starting from any byte position, the next byte is taken as an opcode, and at least one reset_o pulse has occurred.
- R10: An identification request while a reply is in progress is ignored and the reply continues. Reset pulses and writes do not disturb a reply.
- R11: When rx_valid_i is low, no byte is consumed and the parser position is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_valid_i | input | 1 | Received byte valid for one cycle |
| rx_data_i | input | 8 | Received byte |
| tx_ready_i | input | 1 | Transmitter accepts tx_data_o |
| tx_valid_o | output | 1 | Reply byte available |
| tx_data_o | output | 8 | Reply byte |
| reset_o | output | 1 | Soft reset pulse |
| run_o | output | 1 | Arm/run pulse |
| wr_o | output | 1 | Register write strobe |
| wr_addr_o | output | 8 | Opcode of the long command |
| wr_data_o | output | 32 | Assembled argument word |
| wr_kind_o | output | 3 | Decoded target register kind |
| wr_stage_o | output | 2 | Trigger stage of the write |

## Verification
The identification reply runs on its own while the parser keeps taking bytes, so a reply byte can be on the transmit port in the same cycle as a write strobe or a reset pulse. The bench provokes this by sending an identification request, then at once a second request, a zero byte and a full trigger-register command. During this sequence tx_ready_i stalls two cycles out of three. A behavioural model built from queues predicts every output each cycle, and any disagreement in the reply byte order, the strobe timing or the pulses is reported.

// File: rtl/la_cmd_pkg.sv
package la_cmd_pkg;
  typedef enum logic [2:0] {
    KIND_NONE  = 3'd0,
    KIND_DIV   = 3'd1,
    KIND_SIZE  = 3'd2,
    KIND_FLAGS = 3'd3,
    KIND_TMASK = 3'd4,
    KIND_TVAL  = 3'd5,
    KIND_TCFG  = 3'd6
  } wr_kind_e;

  localparam logic [7:0] OP_RESET = 8'h00;
  localparam logic [7:0] OP_RUN   = 8'h01;
  localparam logic [7:0] OP_ID    = 8'h02;
  localparam logic [7:0] OP_DIV   = 8'h80;
  localparam logic [7:0] OP_SIZE  = 8'h81;
  localparam logic [7:0] OP_FLAGS = 8'h82;
  localparam logic [3:0] OP_TRIG_HI = 4'hC;
  localparam int unsigned STAGE_FIELD_W = 2;
endpackage

// File: rtl/la_cmd_parser.sv
module la_cmd_parser
  import la_cmd_pkg::*;
#(
  parameter int unsigned ARG_BYTES = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     rx_valid_i,
  input  logic [7:0]               rx_data_i,
  output logic                     reset_o,
  output logic                     run_o,
  output logic                     id_o,
  output logic                     done_o,
  output logic [7:0]               opcode_o,
  output logic [8*ARG_BYTES-1:0]   arg_o
);
  localparam int unsigned ARG_W = 8 * ARG_BYTES;
  localparam int unsigned CNT_W = $clog2(ARG_BYTES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ARG_BYTES - 1);

  logic             in_long_q;
  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       opcode_q;
  logic [ARG_W-1:0] arg_q;
  logic             reset_q, run_q, id_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_long_q <= 1'b0;
      cnt_q     <= '0;
      opcode_q  <= '0;
      arg_q     <= '0;
      reset_q   <= 1'b0;
      run_q     <= 1'b0;
      id_q      <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      reset_q <= 1'b0;
      run_q   <= 1'b0;
      id_q    <= 1'b0;
      done_q  <= 1'b0;
      if (rx_valid_i) begin
        if (!in_long_q) begin
          if (rx_data_i[7]) begin
            in_long_q <= 1'b1;
            cnt_q     <= '0;
            opcode_q  <= rx_data_i;
          end else begin
            reset_q <= (rx_data_i == OP_RESET);
            run_q   <= (rx_data_i == OP_RUN);
            id_q    <= (rx_data_i == OP_ID);
          end
        end else begin
          // first argument byte ends up in the low byte
          arg_q <= {rx_data_i, arg_q[ARG_W-1:8]};
          cnt_q <= cnt_q + CNT_W'(1);
          if (cnt_q == LAST) begin
            in_long_q <= 1'b0;
            done_q    <= 1'b1;
          end
        end
      end
    end
  end

  assign reset_o  = reset_q;
  assign run_o    = run_q;
  assign id_o     = id_q;
  assign done_o   = done_q;
  assign opcode_o = opcode_q;
  assign arg_o    = arg_q;

  p_pulse_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({reset_q, run_q, id_q, done_q}));

  p_short_from_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reset_q || run_q || id_q) |-> $past(rx_valid_i && !in_long_q));

  p_done_after_arg_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> $past(rx_valid_i && in_long_q));

  p_hold_no_byte_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_valid_i |=> $stable(in_long_q) && $stable(cnt_q));
endmodule

// File: rtl/la_cmd_decode.sv
module la_cmd_decode
  import la_cmd_pkg::*;
#(
  parameter int unsigned NUM_STAGES = 4
) (
  input  logic [7:0]               opcode_i,
  output wr_kind_e                 kind_o,
  output logic [STAGE_FIELD_W-1:0] stage_o
);
  logic [NUM_STAGES-1:0] stage_hit;

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
    assign stage_hit[s] = (opcode_i[7:4] == OP_TRIG_HI)
                       && (opcode_i[3:2] == STAGE_FIELD_W'(s))
                       && (opcode_i[1:0] != 2'b11);
  end

  always_comb begin
    kind_o = KIND_NONE;
    if (opcode_i == OP_DIV)        kind_o = KIND_DIV;
    else if (opcode_i == OP_SIZE)  kind_o = KIND_SIZE;
    else if (opcode_i == OP_FLAGS) kind_o = KIND_FLAGS;
    else if (|stage_hit) begin
      case (opcode_i[1:0])
        2'd0:    kind_o = KIND_TMASK;
        2'd1:    kind_o = KIND_TVAL;
        default: kind_o = KIND_TCFG;
      endcase
    end
  end

  assign stage_o = opcode_i[3:2];
endmodule

// File: rtl/la_id_reply.sv
module la_id_reply #(
  parameter int unsigned                 REPLY_BYTES = 4,
  parameter logic [8*REPLY_BYTES-1:0]    REPLY_WORD  = 32'h4F4C5331
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       tx_ready_i,
  output logic       tx_valid_o,
  output logic [7:0] tx_data_o
);
  localparam int unsigned IDX_W = $clog2(REPLY_BYTES);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(REPLY_BYTES - 1);

  logic             busy_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (busy_q) begin
      // requests during a reply are dropped
      if (tx_ready_i) begin
        idx_q <= idx_q + IDX_W'(1);
        if (idx_q == LAST) busy_q <= 1'b0;
      end
    end else if (start_i) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
    end
  end

  assign tx_valid_o = busy_q;
  assign tx_data_o  = REPLY_WORD[{idx_q, 3'b000} +: 8];

  p_tx_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=> tx_valid_o && $stable(tx_data_o));

  p_stall_keep_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !tx_ready_i) |=> busy_q && $stable(idx_q));
endmodule

// File: rtl/la_cmd_rx.sv
module la_cmd_rx
  import la_cmd_pkg::*;
#(
  parameter int unsigned ARG_BYTES   = 4,
  parameter int unsigned NUM_STAGES  = 4,
  parameter int unsigned REPLY_BYTES = 4,
  parameter logic [8*REPLY_BYTES-1:0] REPLY_WORD = 32'h4F4C5331
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     rx_valid_i,
  input  logic [7:0]               rx_data_i,
  input  logic                     tx_ready_i,
  output logic                     tx_valid_o,
  output logic [7:0]               tx_data_o,
  output logic                     reset_o,
  output logic                     run_o,
  output logic                     wr_o,
  output logic [7:0]               wr_addr_o,
  output logic [8*ARG_BYTES-1:0]   wr_data_o,
  output logic [2:0]               wr_kind_o,
  output logic [STAGE_FIELD_W-1:0] wr_stage_o
);
  logic     id_req;
  wr_kind_e kind;

  la_cmd_parser #(.ARG_BYTES(ARG_BYTES)) u_parser (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rx_valid_i(rx_valid_i),
    .rx_data_i (rx_data_i),
    .reset_o   (reset_o),
    .run_o     (run_o),
    .id_o      (id_req),
    .done_o    (wr_o),
    .opcode_o  (wr_addr_o),
    .arg_o     (wr_data_o)
  );

  la_cmd_decode #(.NUM_STAGES(NUM_STAGES)) u_decode (
    .opcode_i(wr_addr_o),
    .kind_o  (kind),
    .stage_o (wr_stage_o)
  );

  assign wr_kind_o = kind;

  la_id_reply #(.REPLY_BYTES(REPLY_BYTES), .REPLY_WORD(REPLY_WORD)) u_reply (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (id_req),
    .tx_ready_i(tx_ready_i),
    .tx_valid_o(tx_valid_o),
    .tx_data_o (tx_data_o)
  );
endmodule

// File: tb/la_cmd_rx_test.sv
module la_cmd_rx_test;
  localparam int NUM_STAGES = 4;
  localparam int LIMIT = 150000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rx_valid_i = 1'b0;
  logic [7:0]  rx_data_i = 8'h00;
  logic        tx_ready_i = 1'b1;
  logic        tx_valid_o;
  logic [7:0]  tx_data_o;
  logic        reset_o, run_o, wr_o;
  logic [7:0]  wr_addr_o;
  logic [31:0] wr_data_o;
  logic [2:0]  wr_kind_o;
  logic [1:0]  wr_stage_o;

  la_cmd_rx uut (
    .clk_i(clk), .rst_ni(rst_ni), .rx_valid_i(rx_valid_i), .rx_data_i(rx_data_i),
    .tx_ready_i(tx_ready_i), .tx_valid_o(tx_valid_o), .tx_data_o(tx_data_o),
    .reset_o(reset_o), .run_o(run_o), .wr_o(wr_o), .wr_addr_o(wr_addr_o),
    .wr_data_o(wr_data_o), .wr_kind_o(wr_kind_o), .wr_stage_o(wr_stage_o)
  );

  always #10 clk = ~clk;

  int    checks = 0;
  int    fails = 0;
  int    cyc = 0;
  bit    finished = 1'b0;
  bit    stall = 1'b0;
  string cur_req = "R1";

  // reference model state
  bit          m_long = 0;
  int          m_cnt = 0;
  int          m_op = 0;
  logic [31:0] m_word = 0;
  bit          m_id = 0;
  bit          e_reset = 0, e_run = 0, e_wr = 0;
  int          e_addr = 0, e_kind = 0, e_stage = 0;
  logic [31:0] e_data = 0;
  logic [7:0]  txq[$];

  function automatic int kind_of(int op);
    if (op == 8'h80) return 1;
    if (op == 8'h81) return 2;
    if (op == 8'h82) return 3;
    if (op >= 8'hC0 && op < 8'hC0 + 4 * NUM_STAGES && (op % 4) != 3) return 4 + (op % 4);
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_ni) begin
      m_long = 0; m_cnt = 0; m_id = 0;
      e_reset = 0; e_run = 0; e_wr = 0;
      txq.delete();
    end else begin
      if (txq.size() != 0) begin
        if (tx_ready_i) void'(txq.pop_front());
      end else if (m_id) begin
        txq.push_back(8'h31); txq.push_back(8'h53);
        txq.push_back(8'h4C); txq.push_back(8'h4F);
      end
      m_id = 0; e_reset = 0; e_run = 0; e_wr = 0;
      if (rx_valid_i) begin
        if (!m_long) begin
          if (rx_data_i >= 8'h80) begin
            m_long = 1; m_cnt = 0; m_word = 0; m_op = int'(rx_data_i);
          end else if (rx_data_i == 8'h00) e_reset = 1;
          else if (rx_data_i == 8'h01) e_run = 1;
          else if (rx_data_i == 8'h02) m_id = 1;
        end else begin
          m_word = m_word | (32'(rx_data_i) << (8 * m_cnt));
          m_cnt++;
          if (m_cnt == 4) begin
            m_long = 0; e_wr = 1; e_addr = m_op; e_data = m_word;
            e_kind = kind_of(m_op); e_stage = (m_op / 4) % 4;
          end
        end
      end
    end
  end

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", cur_req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      chk("reset_o", 32'(reset_o), 32'(e_reset));
      chk("run_o", 32'(run_o), 32'(e_run));
      chk("wr_o", 32'(wr_o), 32'(e_wr));
      chk("tx_valid_o", 32'(tx_valid_o), 32'(txq.size() != 0));
      if (txq.size() != 0) chk("tx_data_o", 32'(tx_data_o), 32'(txq[0]));
      if (e_wr) begin
        chk("wr_addr_o", 32'(wr_addr_o), 32'(e_addr));
        chk("wr_data_o", wr_data_o, e_data);
        chk("wr_kind_o", 32'(wr_kind_o), 32'(e_kind));
        if (e_kind >= 4) chk("wr_stage_o", 32'(wr_stage_o), 32'(e_stage));
      end
      cyc++;
      if (cyc > LIMIT) begin
        checks++; fails++;
        $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, LIMIT);
        finish_run();
      end
    end
  end

  always @(negedge clk) tx_ready_i = stall ? ((cyc % 3) == 2) : 1'b1;

  task automatic send(logic [7:0] b);
    rx_valid_i = 1'b1; rx_data_i = b;
    @(negedge clk);
    rx_valid_i = 1'b0;
  endtask

  task automatic gap(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_long(logic [7:0] op, logic [31:0] d, int spacing);
    send(op); gap(spacing);
    for (int i = 0; i < 4; i++) begin
      send(d[8*i +: 8]); gap(spacing);
    end
  endtask

  initial begin
    cur_req = "R1";
    gap(3);
    rst_ni = 1'b1;
    gap(3);

    cur_req = "R2";
    send(8'h00); gap(2); send(8'h01); send(8'h00); gap(2);

    cur_req = "R3";
    send(8'h02); gap(8);
    stall = 1'b1;
    send(8'h02); gap(20);
    stall = 1'b0;

    cur_req = "R4";
    send(8'h05); send(8'h7F); send(8'h01); send(8'h03); gap(3);

    cur_req = "R5";
    send_long(8'h80, 32'h1234_5678, 0);
    send_long(8'h81, 32'hA0B0_C0D0, 1);
    cur_req = "R7";
    send_long(8'h82, 32'h0000_00FF, 2);
    send_long(8'hA7, 32'hDEAD_BEEF, 0);
    gap(2);

    cur_req = "R6";
    send_long(8'hC0, 32'h0001_0200, 0);
    send_long(8'h80, 32'h0000_0000, 0);
    gap(3);

    cur_req = "R8";
    for (int s = 0; s < 4; s++)
      for (int k = 0; k < 4; k++)
        send_long(8'(8'hC0 + 4 * s + k), 32'h1000_0000 * s + 32'h0101_0101 * k + 32'hA5, 0);
    gap(2);

    cur_req = "R9";
    for (int k = 0; k < 4; k++) begin
      send(8'h81);
      for (int j = 0; j < k; j++) send(8'(8'h11 * (j + 1)));
      for (int z = 0; z < 5; z++) send(8'h00);
      send(8'h01);
      gap(2);
    end

    cur_req = "R11";
    send(8'h82); gap(5); send(8'h44); gap(7); send(8'h33); gap(3);
    send(8'h22); gap(4); send(8'h11); gap(3);

    cur_req = "R10";
    stall = 1'b1;
    send(8'h02); gap(2);
    send(8'h02); send(8'h00);
    send_long(8'hC5, 32'hCAFE_F00D, 0);
    send(8'h02); gap(25);
    stall = 1'b0;
    gap(10);
    finish_run();
  end
endmodule